// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block is a bus master that carries out one transfer of 1, 2, 3 or 4 bytes at a time over a 16-bit data bus. The width of the slave's data port is not known in advance. The slave reports it in the acknowledge it returns for each bus operation. One acknowledge line means the port is 8 bits wide, the other means it is 16 bits wide. The sequencer then moves one or two bytes in that operation. It advances the address, reloads the size code with the count of bytes still owed, and starts another operation. This repeats until the whole operand has moved. The same request can therefore take one, two, three or four bus operations, depending only on what the slave answers.

Reads are rebuilt into a right-justified 32-bit result. Writes are broken up from a right-justified 32-bit operand. Byte 0, the most significant byte of the operand, always goes first and at the lowest address. Each operation has a wait-state limit. When no acknowledge arrives within that limit, the transfer is abandoned with a bus-error flag. An illegal acknowledge is also abandoned with a bus-error flag. Every transfer ends with a one-cycle done pulse. Addresses are taken as aligned: the leading byte of every operation always rides on the upper data lane.

Top module: `busSizeSeq`

## Requirements
- R1: While reset is held and right after it, the strobe `busAsN` is high, `done` and `busErr` are low and `reqReady` is high.
- R2: `busSize` gives the bytes still owed by the transfer: 01 for one, 10 for two, 11 for three, 00 for four. `reqSize` uses the same encoding. `busAddr`, `busSize` and `busRdWr` stay constant for as long as `busAsN` is low.
- R3: An acknowledge of `ackN` = 2'b10 (bit 0 low) marks an 8-bit port. Exactly one byte moves in that operation, on `busDataIn[15:8]` / `busDataOut[15:8]`.
- R4: An acknowledge of `ackN` = 2'b01 (bit 1 low) marks a 16-bit port. Two bytes move in that operation, the earlier byte on the upper lane, or one byte on the upper lane when only one is owed. So a 3-byte transfer takes an operation of size 11 followed by one of size 01.
- R5: Bytes move in ascending order, byte 0 (the most significant byte of the right-justified operand) first. After each operation `busAddr` advances by the number of bytes just moved.
- R6: A read returns its bytes in `rData`, right-justified, byte 0 most significant, with unused upper bits zero.
- R7: While `ackN` stays 2'b11 the strobe is held and wait states are inserted. A slave that answers after any number of wait cycles below `WAIT_MAX` completes normally.
- R8: If `ackN` stays 2'b11 for `WAIT_MAX` consecutive strobe cycles, the strobe is released, `done` and `busErr` pulse together, and the block returns to idle.
- R9: An acknowledge of `ackN` = 2'b00 ends the transfer with `done` and `busErr` pulsing together.
- R10: `done` is a single-cycle pulse, high in the cycle after the cycle in which the final acknowledge was presented. `rData` is valid while it is high.
- R11: Between two operations of the same transfer, `busAsN` goes high for at least one cycle.
- R12: `reqValid` is ignored while `reqReady` is low. Such a pulse changes neither the bus traffic nor the result of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a transfer (taken only when `reqReady`) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Start address |
| reqSize | input | 2 | Byte count code (01/10/11/00 = 1/2/3/4) |
| reqWData | input | 32 | Right-justified write operand |
| reqReady | output | 1 | Idle, able to take a request |
| busAddr | output | ADDR_W | Address of the current operation |
| busSize | output | 2 | Bytes still owed, same code as `reqSize` |
| busRdWr | output | 1 | 1 = read, 0 = write |
| busAsN | output | 1 | Active-low address strobe |
| busDataOut | output | 16 | Write data, leading byte on [15:8] |
| busDataOe | output | 1 | Write data is being driven |
| busDataIn | input | 16 | Read data from the slave |
| ackN | input | 2 | Active-low acknowledge: [1] 16-bit port, [0] 8-bit port |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busErr | output | 1 | With `done`: transfer failed |
| rData | output | 32 | Assembled read result |

## Verification
The bench aims first at how operations are split. It runs 1-, 2-, 3- and 4-byte transfers against both port widths and logs every strobe. A sequencer that reads the acknowledge wrongly would show too many or too few operations, or the wrong run of size codes. The 3-byte case on a 16-bit port catches a sequencer that moves two bytes when only one is owed. A mistake in byte order or lane use would show up as a scrambled read result or as slave memory holding the bytes in the wrong places. On timing, the bench puts the acknowledge at one cycle short of the wait limit and also withholds it entirely. An off-by-one counter would either fail a legal transfer or hold the strobe for the wrong number of cycles. Finally, it issues an illegal acknowledge and a stray request while a transfer is busy. Mishandling either would show up as a missing error flag or as extra, corrupted bus traffic.

// File: rtl/busSizePkg.sv
package busSizePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_GAP  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic step;      // an operation completed this cycle
    logic twoBytes;  // the completed operation moved two bytes
  } dpStrobe_t;

  // active-low acknowledge encodings: bit1 = word port, bit0 = byte port
  localparam logic [1:0] ACK_NONE = 2'b11;
  localparam logic [1:0] ACK_BYTE = 2'b10;
  localparam logic [1:0] ACK_WORD = 2'b01;
  localparam logic [1:0] ACK_BAD  = 2'b00;

endpackage

// File: rtl/busSizeCtrl.sv
module busSizeCtrl
  import busSizePkg::*;
#(
  parameter int WAIT_MAX = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] ackN,
  input  logic [2:0] remCnt,
  output dpStrobe_t  strobe,
  output logic       busAsN,
  output logic       reqReady,
  output logic       done,
  output logic       busErr
);

  localparam int CW = $clog2(WAIT_MAX + 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_MAX - 1);

  seqState_t state, nextState;
  logic [CW-1:0] waitCnt;
  logic finish, fail;

  always_comb begin
    strobe    = '0;
    nextState = state;
    finish    = 1'b0;
    fail      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          nextState   = ST_BUS;
        end
      end
      ST_BUS: begin
        case (ackN)
          ACK_NONE: begin
            if (waitCnt == WAIT_LAST) begin
              fail      = 1'b1;
              nextState = ST_IDLE;
            end
          end
          ACK_BYTE, ACK_WORD: begin
            strobe.step     = 1'b1;
            strobe.twoBytes = (ackN == ACK_WORD) && (remCnt >= 3'd2);
            if ((strobe.twoBytes ? 3'd2 : 3'd1) == remCnt) begin
              finish    = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_GAP;
            end
          end
          default: begin
            fail      = 1'b1;
            nextState = ST_IDLE;
          end
        endcase
      end
      ST_GAP:  nextState = ST_BUS;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      done    <= 1'b0;
      busErr  <= 1'b0;
    end else begin
      state   <= nextState;
      waitCnt <= (state == ST_BUS && ackN == ACK_NONE && !fail) ? waitCnt + 1'b1 : '0;
      done    <= finish | fail;
      busErr  <= fail;
    end
  end

  assign busAsN   = (state != ST_BUS);
  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/busSizeData.sv
module busSizeData
  import busSizePkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWData,
  input  logic [15:0]       busDataIn,
  output logic [2:0]        remCnt,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              isWrite,
  output logic [15:0]       busDataOut,
  output logic [31:0]       rData
);

  logic [ADDR_W-1:0] addrR;
  logic [2:0]        remR;
  logic [31:0]       opR;
  logic [31:0]       accR;
  logic              wrR;
  logic [2:0]        lead, follow;

  function automatic logic [7:0] pickByte(input logic [31:0] w, input logic [2:0] pos);
    return w[{pos[1:0], 3'b000} +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR <= '0;
      remR  <= '0;
      opR   <= '0;
      accR  <= '0;
      wrR   <= 1'b0;
    end else if (strobe.load) begin
      addrR <= reqAddr;
      remR  <= (reqSize == 2'b00) ? 3'd4 : {1'b0, reqSize};
      opR   <= reqWData;
      accR  <= '0;
      wrR   <= reqWrite;
    end else if (strobe.step) begin
      addrR <= addrR + (strobe.twoBytes ? ADDR_W'(2) : ADDR_W'(1));
      remR  <= remR - (strobe.twoBytes ? 3'd2 : 3'd1);
      if (!wrR) begin
        accR <= strobe.twoBytes ? {accR[15:0], busDataIn} : {accR[23:0], busDataIn[15:8]};
      end
    end
  end

  // leading byte of the remaining operand sits at byte index remR-1
  assign lead       = remR - 3'd1;
  assign follow     = remR - 3'd2;
  assign busDataOut = {pickByte(opR, lead), (remR >= 3'd2) ? pickByte(opR, follow) : 8'h00};
  assign remCnt     = remR;
  assign busAddr    = addrR;
  assign busSize    = remR[1:0];
  assign isWrite    = wrR;
  assign rData      = accR;

endmodule

// File: rtl/busSizeSeq.sv
module busSizeSeq
  import busSizePkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WAIT_MAX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWData,
  output logic              reqReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busRdWr,
  output logic              busAsN,
  output logic [15:0]       busDataOut,
  output logic              busDataOe,
  input  logic [15:0]       busDataIn,
  input  logic [1:0]        ackN,
  output logic              done,
  output logic              busErr,
  output logic [31:0]       rData
);

  dpStrobe_t strobe;
  logic [2:0] remCnt;
  logic       isWrite;

  busSizeCtrl #(.WAIT_MAX(WAIT_MAX)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ackN     (ackN),
    .remCnt   (remCnt),
    .strobe   (strobe),
    .busAsN   (busAsN),
    .reqReady (reqReady),
    .done     (done),
    .busErr   (busErr)
  );

  busSizeData #(.ADDR_W(ADDR_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWData   (reqWData),
    .busDataIn  (busDataIn),
    .remCnt     (remCnt),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .isWrite    (isWrite),
    .busDataOut (busDataOut),
    .rData      (rData)
  );

  assign busRdWr   = !isWrite;
  assign busDataOe = isWrite && !busAsN;

endmodule

// File: rtl/busSizeSeqChk.sv
module busSizeSeqChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busRdWr,
  input logic              busAsN,
  input logic [1:0]        ackN,
  input logic              done,
  input logic              busErr
);

  // R2: request fields hold while the strobe stays low through a wait state
  a_r2_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busAsN && $past(!busAsN) && $past(ackN == 2'b11))
      |-> ($stable(busAddr) && $stable(busSize) && $stable(busRdWr)));

  // R11: any acknowledge ends the operation; strobe is high next cycle
  a_r11_strobe_release: assert property (@(posedge clk) disable iff (!rstN)
    (!busAsN && ackN != 2'b11) |=> busAsN);

  // R10: done lasts exactly one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: done follows a cycle in which the strobe was low
  a_r10_done_after_op: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(!busAsN));

  // R8, R9: an error is only flagged alongside done
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> done);

  // R12: no strobe while the block reports itself idle
  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busAsN |-> !reqReady);

endmodule

bind busSizeSeq busSizeSeqChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .busAddr  (busAddr),
  .busSize  (busSize),
  .busRdWr  (busRdWr),
  .busAsN   (busAsN),
  .ackN     (ackN),
  .done     (done),
  .busErr   (busErr)
);

// File: tb/test_busSizeSeq.sv
module test_busSizeSeq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int WAIT_LIM   = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = 2'b00;
  logic [31:0]       reqWData = '0;
  logic              reqReady;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0]        busSize;
  logic              busRdWr;
  logic              busAsN;
  logic [15:0]       busDataOut;
  logic              busDataOe;
  logic [15:0]       busDataIn = '0;
  logic [1:0]        ackN = 2'b11;
  logic              done;
  logic              busErr;
  logic [31:0]       rData;

  busSizeSeq #(.ADDR_W(ADDR_W), .WAIT_MAX(WAIT_LIM)) i_busSizeSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWData(reqWData),
    .reqReady(reqReady), .busAddr(busAddr), .busSize(busSize),
    .busRdWr(busRdWr), .busAsN(busAsN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .ackN(ackN),
    .done(done), .busErr(busErr), .rData(rData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // slave model: mode 0 = 8-bit, 1 = 16-bit, 2 = never answers, 3 = illegal ack
  logic [7:0] mem [64];
  int  portMode = 0;
  int  waitN    = 0;
  int  cnt      = 0;
  int  opCnt    = 0;
  int  strobeCyc = 0;
  int  strobeStarts = 0;
  int  tick     = 0;
  int  lastAckTick = 0;
  logic prevAsN = 1'b1;
  logic [ADDR_W-1:0] opAddr [8];
  logic [1:0]        opSize [8];
  logic              sizeMoved = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick++;
    if (!busAsN) begin
      strobeCyc++;
      if (prevAsN) strobeStarts++;
      if (cnt > 0 && (busSize != opSize[(opCnt < 8) ? opCnt : 7] || busAddr != opAddr[(opCnt < 8) ? opCnt : 7]))
        sizeMoved = 1'b1;
      if (cnt == 0 && opCnt < 8) begin
        opAddr[opCnt] = busAddr;
        opSize[opCnt] = busSize;
      end
      if (cnt == waitN && portMode < 2) begin
        if (portMode == 0) begin
          ackN = 2'b10;
          if (busRdWr) busDataIn = {mem[busAddr[5:0]], 8'h5A};
          else mem[busAddr[5:0]] = busDataOut[15:8];
        end else begin
          ackN = 2'b01;
          if (busRdWr) busDataIn = {mem[busAddr[5:0]], mem[busAddr[5:0] + 6'd1]};
          else begin
            mem[busAddr[5:0]] = busDataOut[15:8];
            if (busSize != 2'b01) mem[busAddr[5:0] + 6'd1] = busDataOut[7:0];
          end
        end
        opCnt++;
        lastAckTick = tick;
      end else if (cnt == waitN && portMode == 3) begin
        ackN = 2'b00;
        lastAckTick = tick;
      end else begin
        ackN = 2'b11;
      end
      cnt++;
    end else begin
      ackN = 2'b11;
      cnt  = 0;
    end
    prevAsN = busAsN;
  end

  // runs one transfer; returns done count, done tick, error flag and read data
  int doneCnt, doneTick;
  logic errSeen;
  logic [31:0] rdSeen;

  task automatic runXfer(input bit wr, input int base, input logic [1:0] sz,
                         input logic [31:0] wd, input int mode, input int waits,
                         input bit inject);
    portMode = mode; waitN = waits;
    opCnt = 0; strobeCyc = 0; strobeStarts = 0; sizeMoved = 1'b0;
    doneCnt = 0; doneTick = 0; errSeen = 1'b0; rdSeen = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(base); reqSize = sz; reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (inject && i == 1) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ADDR_W'(40); reqSize = 2'b00; reqWData = 32'hDEADBEEF;
      end else begin
        reqValid = 1'b0;
      end
      if (done) begin
        doneCnt++;
        if (doneCnt == 1) begin
          doneTick = tick; errSeen = busErr; rdSeen = rData;
        end
      end
      if (doneCnt > 0 && !done) break;
    end
    reqValid = 1'b0;
  endtask

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 4 : int'(sz);
  endfunction

  // checks a completed transfer against the splitting and ordering rules
  task automatic checkOk(input string tag, input bit wr, input int base,
                         input logic [1:0] sz, input logic [31:0] wd, input int mode);
    int n, expOps, moved, rem;
    logic [31:0] expRd;
    n = nBytes(sz);
    expOps = (mode == 0) ? n : (n + 1) / 2;
    chk(doneCnt == 1, {tag, " R10 single done"}, doneCnt, 1);
    chk(doneTick == lastAckTick + 1, {tag, " R10 done timing"}, doneTick - lastAckTick, 1);
    chk(!errSeen, {tag, " R8 no error"}, errSeen, 0);
    chk(opCnt == expOps, {tag, (mode == 0) ? " R3 op count" : " R4 op count"}, opCnt, expOps);
    chk(strobeStarts == expOps, {tag, " R11 strobe gaps"}, strobeStarts, expOps);
    chk(!sizeMoved, {tag, " R2 fields held"}, sizeMoved, 0);
    moved = 0;
    for (int k = 0; k < expOps && k < 8; k++) begin
      rem = n - moved;
      chk(opSize[k] == 2'(rem % 4), {tag, " R2 size code"}, opSize[k], rem % 4);
      chk(opAddr[k] == ADDR_W'(base + moved), {tag, " R5 address step"}, opAddr[k], base + moved);
      moved += (mode == 1 && rem >= 2) ? 2 : 1;
    end
    if (wr) begin
      for (int i = 0; i < n; i++)
        chk(mem[base + i] == wd[8 * (n - 1 - i) +: 8], {tag, " R5 byte order"}, mem[base + i], wd[8 * (n - 1 - i) +: 8]);
    end else begin
      expRd = '0;
      for (int i = 0; i < n; i++) expRd = (expRd << 8) | 32'(mem[base + i]);
      chk(rdSeen == expRd, {tag, " R6 read data"}, rdSeen, expRd);
    end
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + seed) & 8'hFF);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  task automatic testReset();
    #1;
    chk(busAsN == 1'b1, "R1 strobe in reset", busAsN, 1);
    chk(done == 1'b0 && busErr == 1'b0, "R1 flags in reset", {done, busErr}, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    chk(busAsN == 1'b1, "R1 strobe after reset", busAsN, 1);
  endtask

  task automatic testWrite(input string tag, input int base, input logic [1:0] sz, input logic [31:0] wd, input int mode);
    clearMem();
    runXfer(1'b1, base, sz, wd, mode, 0, 1'b0);
    checkOk(tag, 1'b1, base, sz, wd, mode);
  endtask

  task automatic testRead(input string tag, input int base, input logic [1:0] sz, input int mode, input int waits, input int seed);
    int n;
    fillMem(seed);
    runXfer(1'b0, base, sz, '0, mode, waits, 1'b0);
    checkOk(tag, 1'b0, base, sz, '0, mode);
    n = (mode == 0) ? nBytes(sz) : (nBytes(sz) + 1) / 2;
    chk(strobeCyc == n * (waits + 1), {tag, " R7 wait cycles"}, strobeCyc, n * (waits + 1));
  endtask

  task automatic testTimeout();
    runXfer(1'b0, 8, 2'b10, '0, 2, 0, 1'b0);
    chk(doneCnt == 1, "R8 timeout done", doneCnt, 1);
    chk(errSeen == 1'b1, "R8 timeout error", errSeen, 1);
    chk(strobeCyc == WAIT_LIM, "R8 timeout strobe length", strobeCyc, WAIT_LIM);
    chk(reqReady == 1'b1, "R8 back to idle", reqReady, 1);
  endtask

  task automatic testBadAck();
    runXfer(1'b1, 12, 2'b00, 32'h11223344, 3, 2, 1'b0);
    chk(doneCnt == 1 && errSeen == 1'b1, "R9 illegal ack error", errSeen, 1);
    chk(doneTick == lastAckTick + 1, "R9 error timing", doneTick - lastAckTick, 1);
  endtask

  task automatic testBusyIgnore();
    clearMem();
    runXfer(1'b1, 20, 2'b00, 32'hA1B2C3D4, 0, 1, 1'b1);
    checkOk("busy", 1'b1, 20, 2'b00, 32'hA1B2C3D4, 0);
    chk(mem[40] == 8'h00, "R12 stray request ignored", mem[40], 0);
    repeat (3) @(negedge clk);
    chk(busAsN == 1'b1, "R12 no extra operation", busAsN, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    testReset();
    testWrite("w4b8",  4, 2'b00, 32'h8899AABB, 0);   // R3 R5
    testWrite("w4b16", 8, 2'b00, 32'h01234567, 1);   // R4
    testWrite("w2b8",  2, 2'b10, 32'h0000C3E7, 0);   // R3
    testWrite("w1b16", 6, 2'b01, 32'h0000005F, 1);   // R4
    testWrite("w3b16", 10, 2'b11, 32'h00ABCDEF, 1);  // R4
    testRead("r4b8",  16, 2'b00, 0, 0, 3);           // R6
    testRead("r4b16", 24, 2'b00, 1, 0, 11);          // R6
    testRead("r3b16", 30, 2'b11, 1, 0, 5);           // R4
    testRead("r3b8",  33, 2'b11, 0, 0, 9);
    testRead("r1b8",  7,  2'b01, 0, 0, 21);
    testRead("r2b16wait", 14, 2'b10, 1, 5, 17);      // R7
    testRead("r4b8edge", 18, 2'b00, 0, WAIT_LIM - 1, 2); // R7 R8 boundary
    testTimeout();
    testBadAck();
    testBusyIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule